// File: doc/BRIEF.md
# Dual-Stream Cyclic Convolution Array with Coefficient Lookup Tables

This block is the arithmetic core of a unified forward and inverse cosine/sine transform engine of prime length 7. Such a transform reduces to two length-3 cyclic convolutions with one fixed kernel. This array computes both convolutions at the same time. Stream A and stream B each supply one pre-permuted block of three signed samples. The array returns three results per stream in index order.

The array is a linear chain of three processing elements. Each element owns one kernel coefficient that never changes. Its two products, one per stream, come from a single 16-word table of that coefficient's multiples. Each 8-bit operand is split into a low nibble and a high nibble. Each nibble is looked up on its own, and the two words are joined by a shift and an add, with a correction when the high nibble is negative.

The block travels down the chain one stage per cycle. A phase tag travels with it and tells each element which sample to use. Partial sums move down the chain in step with the block, so the sums leave the far end without any preloading. A new block can be accepted every three cycles.

Top module: `rom_cconv_array`

## Requirements
- R1: While reset is asserted, and until the first block is accepted after reset, `out_valid` is low.
- R2: For an accepted block, `out_a` with index k equals the sum over j of c[j]·a[(k−j) mod 3]. Here a[i] is the signed sample in bits [8i+7:8i] of `blk_a`, and the default kernel is c = (80, −28, −115), which are Q1.7 values.
- R3: `out_b` is formed from `blk_b` with the same kernel and the same index rule, in the same cycle as `out_a`, and independently of it.
- R4: Suppose a block is accepted on clock edge E. Then the result with index k is presented after edge E+3+k.
- R5: Each accepted block yields exactly three output cycles, with `out_valid` high and `out_idx` equal to 0, 1 and 2 on consecutive cycles.
- R6: A block presented three or more cycles after the previous accepted block is accepted. Blocks presented every third cycle give an unbroken output stream.
- R7: A block presented one or two cycles after an accepted block is ignored. It produces no output and does not alter the results of the accepted block.
- R8: Operands at the extremes, −128 and 127, give exact results with no wrap in the 18-bit sums.
- R9: The nibble-split table product equals the exact signed product c[j]·x for every 8-bit operand value x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 1 | Block present on `blk_a` and `blk_b` this cycle |
| blk_a | input | 24 | Stream A block, sample i in bits [8i+7:8i], two's complement |
| blk_b | input | 24 | Stream B block, same layout |
| out_valid | output | 1 | Result present this cycle |
| out_idx | output | 2 | Index k of the presented result |
| out_a | output | 18 | Stream A convolution result, signed |
| out_b | output | 18 | Stream B convolution result, signed |

## Verification
The bench builds the array with its default parameters: length 7, 8-bit operands and the kernel (80, −28, −115). With those values the whole signed operand range of −128 to 127 is small enough to sweep as impulses through every element, so each nibble-split product is checked against exact integer arithmetic. The same values let the bench reach the magnitude limits of the sums, back-to-back streaming at one block every third cycle, and blocks that arrive too early and must be dropped.

// File: rtl/cconv_pkg.sv
// Shared helpers for the cyclic convolution array.
// Assumes a phase value is always smaller than the convolution length.
package cconv_pkg;

    // Sample lane used by element pe while building result index ph: (ph - pe) mod n.
    function automatic int lane_sel(input int ph, input int pe, input int n);
        return (ph + n - (pe % n)) % n;
    endfunction

endpackage

// File: rtl/cconv_ktab.sv
// Fixed multiples table of one kernel coefficient, holding COEF*u for u = 0 .. 2**HW-1.
// It has NPORT ports, and each port reads a low-nibble word and a high-nibble word.
// Assumes COEF is a compile-time constant and the reads are purely combinational.
module cconv_ktab #(
    parameter int CW = 8,
    parameter int HW = 4,
    parameter int NPORT = 2,
    parameter int TW = CW + HW + 1,
    parameter logic signed [CW-1:0] COEF = 8'sd64
) (
    input  logic [2*NPORT-1:0][HW-1:0] rd_addr,
    output logic [2*NPORT-1:0][TW-1:0] rd_word
);
    localparam int DEPTH = 1 << HW;
    localparam logic signed [TW-1:0] CX = TW'(COEF);

    logic signed [TW-1:0] tbl [DEPTH];

    // Table contents: each entry is the coefficient times its address.
    for (genvar u = 0; u < DEPTH; u++) begin : g_ent
        localparam logic signed [TW-1:0] UV = TW'(u);
        assign tbl[u] = CX * UV;
    end

    // Read ports: two half-operand reads for each logical port.
    for (genvar r = 0; r < 2*NPORT; r++) begin : g_rd
        assign rd_word[r] = tbl[rd_addr[r]];
    end
endmodule

// File: rtl/cconv_head.sv
// Array entry stage. It captures a block for both streams and issues phases 0..NPE-1,
// one phase per cycle. A block offered while a phase window is still open is dropped.
// Assumes the surrounding logic offers blocks no more often than it needs.
module cconv_head #(
    parameter int NPE = 3,
    parameter int XW = 8,
    parameter int PW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [NPE*XW-1:0]    in_a,
    input  logic [NPE*XW-1:0]    in_b,
    output logic                 h_vld,
    output logic [PW-1:0]        h_ph,
    output logic [NPE*XW-1:0]    h_a,
    output logic [NPE*XW-1:0]    h_b
);
    localparam logic [PW-1:0] LAST = PW'(NPE - 1);

    logic busy;
    logic accept;

    // Window state: a block is in flight until its last phase has been issued.
    assign busy   = h_vld && (h_ph != LAST);
    assign accept = in_valid && !busy;

    // Capture a new block, step the phase, or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_vld <= 1'b0;
            h_ph  <= '0;
            h_a   <= '0;
            h_b   <= '0;
        end else if (accept) begin
            h_vld <= 1'b1;
            h_ph  <= '0;
            h_a   <= in_a;
            h_b   <= in_b;
        end else if (busy) begin
            h_ph  <= h_ph + PW'(1);
        end else begin
            h_vld <= 1'b0;
        end
    end

    // R7: an open window always advances and is never restarted by an early block.
    a_r7_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (h_vld && h_ph != LAST) |=> (h_vld && h_ph == $past(h_ph) + PW'(1)));

    // R6: an offer with no open window starts a fresh window at phase 0.
    a_r6_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(h_vld && h_ph != LAST)) |=> (h_vld && h_ph == '0));
endmodule

// File: rtl/cconv_pe.sv
// One processing element. It holds coefficient COEF and adds COEF*x to the passing
// partial sum for each stream. Here x is the sample in lane (phase - PE_IDX) mod NPE of
// the passing block. Each product comes from the nibble-split table; the high nibble is
// corrected when its sign bit is set. The block, the phase and both sums advance one stage
// per cycle. Assumes XW is even.
module cconv_pe
    import cconv_pkg::*;
#(
    parameter int NPE = 3,
    parameter int XW = 8,
    parameter int CW = 8,
    parameter int SW = 18,
    parameter int PW = 2,
    parameter int PE_IDX = 0,
    parameter logic signed [CW-1:0] COEF = 8'sd64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_vld,
    input  logic [PW-1:0]         i_ph,
    input  logic [NPE*XW-1:0]     i_a,
    input  logic [NPE*XW-1:0]     i_b,
    input  logic signed [SW-1:0]  i_sa,
    input  logic signed [SW-1:0]  i_sb,
    output logic                  o_vld,
    output logic [PW-1:0]         o_ph,
    output logic [NPE*XW-1:0]     o_a,
    output logic [NPE*XW-1:0]     o_b,
    output logic signed [SW-1:0]  o_sa,
    output logic signed [SW-1:0]  o_sb
);
    localparam int HW  = XW / 2;
    localparam int TW  = CW + HW + 1;
    localparam int PRW = CW + XW;
    localparam logic signed [PRW-1:0] CXP = PRW'(COEF);

    int lane;
    logic signed [XW-1:0]  xa, xb;
    logic [3:0][HW-1:0]    addr;
    logic [3:0][TW-1:0]    word;
    logic signed [PRW-1:0] prod_a, prod_b;

    // Join a low-nibble word and a high-nibble word into the full product.
    function automatic logic signed [PRW-1:0] join_halves(
        input logic [TW-1:0] lo_w, input logic [TW-1:0] hi_w, input logic neg);
        logic signed [PRW-1:0] hi_e;
        hi_e = PRW'($signed(hi_w)) - (neg ? (CXP <<< HW) : PRW'(0));
        return (hi_e <<< HW) + PRW'($signed(lo_w));
    endfunction

    // Choose this element's sample lane for the result index being built.
    always_comb begin
        lane = lane_sel(int'(i_ph), PE_IDX, NPE);
        xa   = i_a[lane*XW +: XW];
        xb   = i_b[lane*XW +: XW];
        addr = {xb[XW-1:HW], xb[HW-1:0], xa[XW-1:HW], xa[HW-1:0]};
    end

    cconv_ktab #(.CW(CW), .HW(HW), .NPORT(2), .TW(TW), .COEF(COEF)) ktab_i (
        .rd_addr (addr),
        .rd_word (word)
    );

    // Product assembly for each stream from its two table words.
    always_comb begin
        prod_a = join_halves(word[0], word[1], xa[XW-1]);
        prod_b = join_halves(word[2], word[3], xb[XW-1]);
    end

    // Stage register: pass the block and phase on, and accumulate into the moving sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld <= 1'b0;
            o_ph  <= '0;
            o_a   <= '0;
            o_b   <= '0;
            o_sa  <= '0;
            o_sb  <= '0;
        end else begin
            o_vld <= i_vld;
            o_ph  <= i_ph;
            o_a   <= i_a;
            o_b   <= i_b;
            o_sa  <= i_vld ? i_sa + SW'(prod_a) : '0;
            o_sb  <= i_vld ? i_sb + SW'(prod_b) : '0;
        end
    end

    // R9: the split lookup matches a direct signed multiply on both ports.
    a_r9_split_product_a: assert property (@(posedge clk) disable iff (!rst_n)
        i_vld |-> (prod_a == PRW'(xa) * CXP));
    a_r9_split_product_b: assert property (@(posedge clk) disable iff (!rst_n)
        i_vld |-> (prod_b == PRW'(xb) * CXP));

    // R5: phases leave each stage in ascending order on consecutive cycles.
    a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_ph != PW'(NPE - 1)) |=> (o_vld && o_ph == $past(o_ph) + PW'(1)));

    // R8: valid sums keep a spare sign bit, so no wrap occurs.
    a_r8_sum_headroom: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (o_sa[SW-1] == o_sa[SW-2] && o_sb[SW-1] == o_sb[SW-2]));
endmodule

// File: rtl/rom_cconv_array.sv
// Linear array of (TLEN-1)/2 elements that computes two length-(TLEN-1)/2 cyclic
// convolutions with one fixed kernel. Element j holds KERNEL[j]. Results leave the last
// element in index order, and the first result follows the accepted block by NPE cycles.
// Assumes TLEN is an odd prime and that the caller reads each result when out_valid is high.
module rom_cconv_array #(
    parameter int TLEN = 7,
    parameter int XW = 8,
    parameter int CW = 8,
    parameter int SW = 18,
    parameter logic [((TLEN-1)/2)*CW-1:0] KERNEL = {-8'sd115, -8'sd28, 8'sd80}
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             blk_valid,
    input  logic [((TLEN-1)/2)*XW-1:0]       blk_a,
    input  logic [((TLEN-1)/2)*XW-1:0]       blk_b,
    output logic                             out_valid,
    output logic [$clog2((TLEN-1)/2)-1:0]    out_idx,
    output logic [SW-1:0]                    out_a,
    output logic [SW-1:0]                    out_b
);
    localparam int NPE = (TLEN - 1) / 2;
    localparam int PW  = $clog2(NPE);

    logic                     st_vld [NPE+1];
    logic [PW-1:0]            st_ph  [NPE+1];
    logic [NPE*XW-1:0]        st_a   [NPE+1];
    logic [NPE*XW-1:0]        st_b   [NPE+1];
    logic signed [SW-1:0]     st_sa  [NPE+1];
    logic signed [SW-1:0]     st_sb  [NPE+1];

    cconv_head #(.NPE(NPE), .XW(XW), .PW(PW)) head_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (blk_valid),
        .in_a     (blk_a),
        .in_b     (blk_b),
        .h_vld    (st_vld[0]),
        .h_ph     (st_ph[0]),
        .h_a      (st_a[0]),
        .h_b      (st_b[0])
    );

    // Sums enter the first element empty.
    assign st_sa[0] = '0;
    assign st_sb[0] = '0;

    for (genvar j = 0; j < NPE; j++) begin : g_pe
        cconv_pe #(
            .NPE(NPE), .XW(XW), .CW(CW), .SW(SW), .PW(PW),
            .PE_IDX(j), .COEF(KERNEL[j*CW +: CW])
        ) pe_i (
            .clk   (clk),
            .rst_n (rst_n),
            .i_vld (st_vld[j]),
            .i_ph  (st_ph[j]),
            .i_a   (st_a[j]),
            .i_b   (st_b[j]),
            .i_sa  (st_sa[j]),
            .i_sb  (st_sb[j]),
            .o_vld (st_vld[j+1]),
            .o_ph  (st_ph[j+1]),
            .o_a   (st_a[j+1]),
            .o_b   (st_b[j+1]),
            .o_sa  (st_sa[j+1]),
            .o_sb  (st_sb[j+1])
        );
    end

    // Results are the last element's registers.
    assign out_valid = st_vld[NPE];
    assign out_idx   = st_ph[NPE];
    assign out_a     = st_sa[NPE];
    assign out_b     = st_sb[NPE];
endmodule

// File: tb/rom_cconv_array_tb.sv
`timescale 1ns/1ps
module rom_cconv_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_valid = 1'b0;
    logic [23:0] blk_a = '0;
    logic [23:0] blk_b = '0;
    logic        out_valid;
    logic [1:0]  out_idx;
    logic [17:0] out_a, out_b;

    typedef struct {
        int    cyc;
        int    idx;
        int    ea;
        int    eb;
        string req;
    } exp_t;

    exp_t sbq[$];
    int   coef[3] = '{80, -28, -115};
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   last_acc = -100;
    bit   finished = 1'b0;

    rom_cconv_array dut_i (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_a(blk_a), .blk_b(blk_b),
        .out_valid(out_valid), .out_idx(out_idx), .out_a(out_a), .out_b(out_b)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int conv(input int x[3], input int k);
        int s = 0;
        for (int j = 0; j < 3; j++) s += coef[j] * x[(k - j + 3) % 3];
        return s;
    endfunction

    // Driver: offer a block for one cycle and queue results only if the rules accept it.
    task automatic send(input int a[3], input int b[3], input string req);
        blk_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            blk_a[i*8 +: 8] = 8'(a[i]);
            blk_b[i*8 +: 8] = 8'(b[i]);
        end
        if (cyc - last_acc >= 3) begin
            last_acc = cyc;
            for (int k = 0; k < 3; k++)
                sbq.push_back('{cyc + 4 + k, k, conv(a, k), conv(b, k), req});
        end
        @(negedge clk);
        blk_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: compare every presented result with the head of the scoreboard.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_valid && !finished) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R7", "unexpected output", $signed(out_a), 0);
            end else begin
                e = sbq.pop_front();
                check(cyc == e.cyc, "R4", {e.req, " latency cycle"}, cyc, e.cyc);
                check(int'(out_idx) == e.idx, "R5", {e.req, " index"}, int'(out_idx), e.idx);
                check($signed(out_a) == e.ea, e.req, "stream A (R2)", $signed(out_a), e.ea);
                check($signed(out_b) == e.eb, e.req, "stream B (R3)", $signed(out_b), e.eb);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", sbq.size());
            summary();
            $finish;
        end
    end

    initial begin
        int a[3];
        int b[3];
        int seed;
        // R1: no output while reset is held, even with a block offered.
        blk_valid = 1'b1;
        idle(3);
        check(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
        blk_valid = 1'b0;
        rst_n = 1'b1;
        for (int n = 0; n < 3; n++) begin
            idle(1);
            check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        end

        // R2/R3: impulses in distinct lanes per stream.
        a = '{1, 0, 0}; b = '{0, 1, 0}; send(a, b, "R2");
        idle(4);
        a = '{0, 0, 1}; b = '{5, -3, 7}; send(a, b, "R3");
        idle(6);

        // R6: back-to-back stream, one block every third cycle.
        seed = 12345;
        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < 3; i++) begin
                seed = seed * 1103515245 + 12345;
                a[i] = ((seed >>> 8) & 255) - 128;
                seed = seed * 1103515245 + 12345;
                b[i] = ((seed >>> 8) & 255) - 128;
            end
            send(a, b, "R6");
            idle(2);
        end
        idle(6);

        // R8: operand extremes.
        a = '{-128, -128, -128}; b = '{127, 127, 127}; send(a, b, "R8"); idle(2);
        a = '{127, -128, 127};   b = '{-128, 127, -128}; send(a, b, "R8"); idle(2);
        a = '{-128, 127, 0};     b = '{0, -128, 127};   send(a, b, "R8");
        idle(6);

        // R7: early offers one and two cycles after an accepted block are dropped.
        a = '{10, 20, 30}; b = '{-1, -2, -3}; send(a, b, "R7");
        a = '{99, 99, 99}; b = '{99, 99, 99}; send(a, b, "R7");
        a = '{-77, 5, 6};  b = '{8, 9, -10};  send(a, b, "R7");
        a = '{3, -4, 11};  b = '{12, 0, -9};  send(a, b, "R7");
        idle(6);

        // R4: long gap, then a single block.
        idle(5);
        a = '{-50, 60, -70}; b = '{1, 2, 3}; send(a, b, "R4");
        idle(6);

        // R9: every operand value through every element, on both streams.
        for (int v = -128; v < 128; v++) begin
            a = '{v, 0, 0}; b = '{0, 0, v};
            send(a, b, "R9");
            idle(2);
        end
        idle(10);

        check(sbq.size() == 0, "R5", "results still pending", sbq.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule